// File: doc/BRIEF.md
# Sample-Sync Pulse Generator

This block makes the one-master-clock sync pulse that marks each pixel sample point in an imaging front end. The pulse either follows the sync pin directly, through a synchroniser, or is built from any periodic signal on that pin. In the built mode a chosen edge of the pin is detected, and the pulse is issued a programmable number of master clocks later. This lets a board drive the sample point from whatever clock of the right rate it already has.

The same timing source gives three more strobes. A video-sample strobe marks the master-clock edge where the video level is taken. A reset-sample strobe can be moved earlier or later around a nominal position. A clamp strobe is a gated copy of the reset-sample strobe. It fires only when the clamp-enable input was high on the master-clock edge that fell inside the sync pulse.

Top module: `sync_pulse_gen`

## Requirements
- R1: While reset is asserted, all outputs `sync_o`, `vsample_o`, `rsample_o` and `clamp_o` are 0.
- R2: With `det_en_i` = 0, `sync_o` follows `pin_i` through a two-flop synchroniser. A pin level first taken at rising clock edge k shows on `sync_o` from edge k+1, and it lasts as long as the pin level lasts.
- R3: With `det_en_i` = 0, the values of `det_rise_i` and `det_delay_i` have no effect on `sync_o`.
- R4: With `det_en_i` = 1 and `det_rise_i` = 1, a 0-to-1 change of `pin_i` first taken at edge k makes `sync_o` high for the one cycle that starts at edge k+2+D, where D is `det_delay_i` (0 to 7).
- R5: With `det_en_i` = 1 and `det_rise_i` = 0, a 1-to-0 change of `pin_i` produces the same pulse with the same timing, counted from the falling change.
- R6: In the detecting mode each selected edge gives a pulse exactly one clock wide, and the edge not selected gives no pulse.
- R7: A selected edge that arrives while a delay is still counting restarts the count. Only the last edge produces a pulse.
- R8: `vsample_o` is high for one cycle. It starts at the first rising clock edge after `sync_o` has gone low, which is two edges after the start of a one-cycle sync pulse.
- R9: `clamp_en_i` is sampled on each rising edge at which `sync_o` is high. `clamp_o` pulses together with the next `rsample_o` only if the sampled value was 1.
- R10: `rsample_o` is a one-cycle strobe. It starts 2, 3, 4 or 5 clocks after the start of the sync pulse for `rst_timing_i` codes 00, 01 (nominal), 10 and 11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 1 | Asynchronous sync pin or periodic source |
| det_en_i | input | 1 | 1 selects edge detection, 0 selects direct pass |
| det_rise_i | input | 1 | Edge select: 1 selects the rising edge, 0 selects the falling edge |
| det_delay_i | input | 3 | Delay, in master clocks, from the detected edge to the pulse |
| clamp_en_i | input | 1 | Clamp request, sampled during the sync pulse |
| rst_timing_i | input | 2 | Position code for the reset-sample strobe |
| sync_o | output | 1 | Internal sample-sync pulse |
| vsample_o | output | 1 | Video sample strobe |
| rsample_o | output | 1 | Reset-sample strobe |
| clamp_o | output | 1 | Clamp strobe |

## Verification
The delay restart is the hardest case to reach. It needs a second selected edge to arrive while the counter is still counting, so the bench sends a rise, a fall and a second rise within four clocks, with a five-clock delay. It then checks that exactly one pulse appears, timed from the last rise. The clamp sampling point is also narrow, because the request counts only on the one edge inside the sync pulse. The bench therefore raises `clamp_en_i` for a single cycle, placed first on that edge and then one cycle on either side of it.

// File: rtl/sps_pkg.sv
package sps_pkg;
  typedef enum logic [1:0] {
    RT_EARLY   = 2'b00,
    RT_NOMINAL = 2'b01,
    RT_LATE1   = 2'b10,
    RT_LATE2   = 2'b11
  } rst_timing_e;

  // Clocks from sync pulse start to the nominal reset-sample strobe
  localparam int unsigned NOMINAL_LAG = 3;
endpackage

// File: rtl/sps_sync.sv
module sps_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/sps_edge_delay.sv
module sps_edge_delay #(
  parameter int unsigned DELAY_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic               level_i,
  input  logic               rise_i,
  input  logic [DELAY_W-1:0] delay_i,
  output logic               pulse_o
);
  logic               level_q;
  logic               pend_q, pend_d;
  logic               pulse_q, pulse_d;
  logic [DELAY_W-1:0] cnt_q, cnt_d;
  logic               edge_hit;
  logic               cnt_en;

  always_comb begin
    edge_hit = en_i & (rise_i ? (level_i & ~level_q) : (~level_i & level_q));
    cnt_en   = en_i & (edge_hit | pend_q);
    cnt_d    = cnt_q;
    pend_d   = pend_q;
    pulse_d  = 1'b0;
    if (!en_i) begin
      pend_d = 1'b0;
    end else if (edge_hit) begin
      // a fresh edge always restarts the delay
      if (delay_i == '0) begin
        pulse_d = 1'b1;
        pend_d  = 1'b0;
      end else begin
        cnt_d  = delay_i;
        pend_d = 1'b1;
      end
    end else if (pend_q) begin
      if (cnt_q == DELAY_W'(1)) begin
        pulse_d = 1'b1;
        pend_d  = 1'b0;
      end else begin
        cnt_d = cnt_q - DELAY_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= 1'b0;
      pend_q  <= 1'b0;
      pulse_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      level_q <= level_i;
      pend_q  <= pend_d;
      pulse_q <= pulse_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/sps_strobe.sv
module sps_strobe
  import sps_pkg::*;
#(
  parameter int unsigned TIMING_W = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sync_i,
  input  logic                clamp_en_i,
  input  logic [TIMING_W-1:0] timing_i,
  output logic                vsample_o,
  output logic                rsample_o,
  output logic                clamp_o
);
  localparam int unsigned LAG_MAX = NOMINAL_LAG - 1 + (2**TIMING_W) - 1;
  localparam int unsigned IDX_W   = $clog2(LAG_MAX + 1);

  logic               sync_q;
  logic               vs_q, vs_d;
  logic               clamp_q;
  logic [LAG_MAX:1]   sh_q, sh_d;
  logic [IDX_W-1:0]   lag_sel;
  logic               sync_rise;

  always_comb begin
    sync_rise = sync_i & ~sync_q;
    vs_d      = sync_q & ~sync_i;
    sh_d[1]   = sync_rise;
    for (int i = 2; i <= LAG_MAX; i++) sh_d[i] = sh_q[i-1];
    lag_sel   = IDX_W'(NOMINAL_LAG - 1) + IDX_W'(timing_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= 1'b0;
      vs_q    <= 1'b0;
      sh_q    <= '0;
      clamp_q <= 1'b0;
    end else begin
      sync_q <= sync_i;
      vs_q   <= vs_d;
      sh_q   <= sh_d;
      if (sync_i) clamp_q <= clamp_en_i;
    end
  end

  assign vsample_o = vs_q;
  assign rsample_o = sh_q[lag_sel];
  assign clamp_o   = sh_q[lag_sel] & clamp_q;
endmodule

// File: rtl/sync_pulse_gen.sv
module sync_pulse_gen
  import sps_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DELAY_W     = 3,
  parameter int unsigned TIMING_W    = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                pin_i,
  input  logic                det_en_i,
  input  logic                det_rise_i,
  input  logic [DELAY_W-1:0]  det_delay_i,
  input  logic                clamp_en_i,
  input  logic [TIMING_W-1:0] rst_timing_i,
  output logic                sync_o,
  output logic                vsample_o,
  output logic                rsample_o,
  output logic                clamp_o
);
  logic [1:0] rst_pipe_q;
  logic       core_rst_n;
  logic       pin_s;
  logic       det_pulse;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign core_rst_n = rst_pipe_q[1];

  sps_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk   (clk),
    .rst_n (core_rst_n),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  sps_edge_delay #(.DELAY_W(DELAY_W)) i_edge (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .en_i    (det_en_i),
    .level_i (pin_s),
    .rise_i  (det_rise_i),
    .delay_i (det_delay_i),
    .pulse_o (det_pulse)
  );

  assign sync_o = det_en_i ? det_pulse : pin_s;

  sps_strobe #(.TIMING_W(TIMING_W)) i_strobe (
    .clk        (clk),
    .rst_n      (core_rst_n),
    .sync_i     (sync_o),
    .clamp_en_i (clamp_en_i),
    .timing_i   (rst_timing_i),
    .vsample_o  (vsample_o),
    .rsample_o  (rsample_o),
    .clamp_o    (clamp_o)
  );
endmodule

// File: rtl/sps_checker.sv
module sps_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       pin_i,
  input logic       det_en_i,
  input logic       clamp_en_i,
  input logic [1:0] rst_timing_i,
  input logic       sync_o,
  input logic       vsample_o,
  input logic       rsample_o,
  input logic       clamp_o
);
  logic [2:0] warm_q;
  logic       warm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            warm_q <= '0;
    else if (warm_q != 3'd7) warm_q <= warm_q + 3'd1;
  end
  assign warm = (warm_q >= 3'd5);

  // R2: direct pass shows the pin two edges later
  p_bypass_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && !det_en_i && $past(!det_en_i) && $past(!det_en_i, 2))
      |-> (sync_o == $past(pin_i, 2)));

  // R6: detected pulse is one clock wide
  p_one_wide_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && det_en_i && sync_o) |=> (!sync_o || !det_en_i));

  // R8: video sample follows the falling sync
  p_vsample_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $fell(sync_o)) |=> vsample_o);

  // R10: early code places the reset strobe two clocks after sync start
  p_early_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && $rose(sync_o) && rst_timing_i == 2'b00 && $stable(rst_timing_i))
      |=> ##1 rsample_o);

  // R9: no clamp request during the pulse means no clamp strobe
  p_no_clamp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && det_en_i && $rose(sync_o) && !clamp_en_i)
      |=> !clamp_o ##1 !clamp_o ##1 !clamp_o ##1 !clamp_o ##1 !clamp_o);
endmodule

bind sync_pulse_gen sps_checker i_sps_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .pin_i        (pin_i),
  .det_en_i     (det_en_i),
  .clamp_en_i   (clamp_en_i),
  .rst_timing_i (rst_timing_i),
  .sync_o       (sync_o),
  .vsample_o    (vsample_o),
  .rsample_o    (rsample_o),
  .clamp_o      (clamp_o)
);

// File: tb/test_sync_pulse_gen.sv
`timescale 1ns/1ps
module test_sync_pulse_gen;
  logic       clk;
  logic       rst_n;
  logic       pin_i;
  logic       det_en_i;
  logic       det_rise_i;
  logic [2:0] det_delay_i;
  logic       clamp_en_i;
  logic [1:0] rst_timing_i;
  logic       sync_o, vsample_o, rsample_o, clamp_o;

  int n_chk = 0;
  int n_bad = 0;
  int f_sync, n_sync, f_vs, n_vs, f_rs, n_rs, f_cl, n_cl;
  int cyc = 0;

  sync_pulse_gen i_sync_pulse_gen (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .det_en_i(det_en_i),
    .det_rise_i(det_rise_i), .det_delay_i(det_delay_i), .clamp_en_i(clamp_en_i),
    .rst_timing_i(rst_timing_i), .sync_o(sync_o), .vsample_o(vsample_o),
    .rsample_o(rsample_o), .clamp_o(clamp_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 20000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: act %0d cycles exp below 20000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic note(input int i, input logic s, inout int f, inout int n);
    if (s) begin
      if (f < 0) f = i;
      n++;
    end
  endtask

  // drive pin pattern from negedge 0; record first index and count of each output
  task automatic capture(input logic lvl0, input int w, input int again, input int cl_at);
    f_sync = -1; n_sync = 0; f_vs = -1; n_vs = 0;
    f_rs = -1; n_rs = 0; f_cl = -1; n_cl = 0;
    for (int i = 0; i < 28; i++) begin
      @(negedge clk);
      if (i > 0) begin
        note(i, sync_o, f_sync, n_sync);
        note(i, vsample_o, f_vs, n_vs);
        note(i, rsample_o, f_rs, n_rs);
        note(i, clamp_o, f_cl, n_cl);
      end
      if (i == 0) pin_i = ~lvl0;
      if (i == w) pin_i = lvl0;
      if (again > 0 && i == again) pin_i = ~lvl0;
      if (cl_at >= 0) clamp_en_i = (i == cl_at);
    end
    pin_i = lvl0;
    clamp_en_i = 1'b0;
    repeat (14) @(negedge clk);
  endtask

  task automatic t_reset;
    rst_n = 1'b0; pin_i = 1'b0; det_en_i = 1'b0; det_rise_i = 1'b1;
    det_delay_i = 3'd0; clamp_en_i = 1'b0; rst_timing_i = 2'b01;
    repeat (3) @(negedge clk);
    pin_i = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 sync", int'(sync_o), 0);
    chk("R1 vsample", int'(vsample_o), 0);
    chk("R1 rsample", int'(rsample_o), 0);
    chk("R1 clamp", int'(clamp_o), 0);
    pin_i = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_bypass;
    det_en_i = 1'b0; det_rise_i = 1'b1; det_delay_i = 3'd0;
    capture(1'b0, 3, 0, -1);
    chk("R2 first", f_sync, 2);
    chk("R2 width", n_sync, 3);
    chk("R8 bypass vsample", f_vs, 6);
    det_rise_i = 1'b0; det_delay_i = 3'd7;
    capture(1'b0, 3, 0, -1);
    chk("R3 first", f_sync, 2);
    chk("R3 width", n_sync, 3);
  endtask

  task automatic t_rise(input logic [2:0] d);
    det_en_i = 1'b1; det_rise_i = 1'b1; det_delay_i = d;
    repeat (4) @(negedge clk);
    capture(1'b0, 10, 0, -1);
    chk("R4 first", f_sync, 3 + int'(d));
    chk("R6 count", n_sync, 1);
    chk("R8 vsample", f_vs, 5 + int'(d));
    chk("R8 vsample count", n_vs, 1);
  endtask

  task automatic t_fall;
    det_en_i = 1'b1; det_rise_i = 1'b0; det_delay_i = 3'd2;
    pin_i = 1'b1;
    repeat (8) @(negedge clk);
    capture(1'b1, 10, 0, -1);
    chk("R5 first", f_sync, 5);
    chk("R6 fall count", n_sync, 1);
    pin_i = 1'b0;
    repeat (8) @(negedge clk);
  endtask

  task automatic t_restart;
    det_en_i = 1'b1; det_rise_i = 1'b1; det_delay_i = 3'd5;
    capture(1'b0, 2, 4, -1);
    chk("R7 first", f_sync, 12);
    chk("R7 count", n_sync, 1);
  endtask

  task automatic t_timing;
    det_en_i = 1'b1; det_rise_i = 1'b1; det_delay_i = 3'd0;
    for (int c = 0; c < 4; c++) begin
      rst_timing_i = 2'(c);
      repeat (3) @(negedge clk);
      capture(1'b0, 10, 0, -1);
      chk("R10 position", f_rs, 5 + c);
      chk("R10 count", n_rs, 1);
    end
    rst_timing_i = 2'b01;
  endtask

  task automatic t_clamp;
    det_en_i = 1'b1; det_rise_i = 1'b1; det_delay_i = 3'd0; rst_timing_i = 2'b01;
    repeat (3) @(negedge clk);
    capture(1'b0, 10, 0, 3);
    chk("R9 in-pulse first", f_cl, 6);
    chk("R9 in-pulse count", n_cl, 1);
    capture(1'b0, 10, 0, 4);
    chk("R9 after-pulse", n_cl, 0);
    chk("R9 strobe still", n_rs, 1);
    capture(1'b0, 10, 0, 2);
    chk("R9 before-pulse", n_cl, 0);
  endtask

  initial begin
    t_reset;
    t_bypass;
    t_rise(3'd0);
    t_rise(3'd3);
    t_rise(3'd7);
    t_fall;
    t_restart;
    t_timing;
    t_clamp;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule